// File: doc/BRIEF.md
# Hardware Debug Breakpoint Match Unit

This block watches a processor core's instruction fetches and data accesses for the addresses held in four debug slots. Each slot has an address register. A shared control register gives each slot two enable bits, a kind (execute, write, port, read-or-write) and a size. When a fetch or a data access matches one or more slots, the unit records which slots matched in a status register. If any matching slot is enabled, it also raises a one-cycle debug-exception request toward the core's trap logic.

A slot that matches but is disabled still has its status bit reported. This happens only when an enabled match or a single-step event actually updates the status. A single-step pulse always updates the status, sets a dedicated step bit and requests the exception. Software loads the slots, the control register and the status register through a simple register write port. All registers can be read back through a select-driven read port.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset, the status output is 0, the exception request is low, the control register reads 0x0000_0400 and every slot address reads 0.
- R2: A control register write stores the written value ORed with the fixed-one mask 0x0000_0400, so bit 10 always reads 1.
- R3: Slot i is enabled when control bit 2i (local) or bit 2i+1 (global) is 1. A match on slots that are all disabled raises no exception and leaves the status unchanged.
- R4: A slot of kind 0 matches when a fetch is presented (fetch_valid=1) whose address is exactly equal to the slot address. Status bit i (bits 3:0) reports slot i.
- R5: The kind field of slot i is control bits 17+4i:16+4i. Kind 1 matches data writes only. Kind 3 matches data reads and writes. Kind 2 never matches.
- R6: The length field of slot i is control bits 19+4i:18+4i. Length codes 0, 1, 2, 3 select 1, 2, 8, 4 bytes. The slot covers the length-aligned region containing its address. A data access of size code s (0..3) covers 2^s bytes from dacc_addr, and a data slot matches when the two byte ranges overlap.
- R7: When the status is updated, bits 3:0 are replaced by the match vector of all four slots, including slots that are disabled.
- R8: A single-step pulse updates the status even with no enabled match, sets status bit 14 and raises the exception. Bit 14 is never cleared by a later check.
- R9: The exception request is registered. It is high for exactly the one cycle after a triggering fetch, access or step, and the status changes on that same clock edge.
- R10: Status bits other than 3:0 and 14 are changed only by register writes. A status write in the same cycle as a check takes priority for the status value, while the exception still fires.
- R11: Register select codes are 0..3 for the slot addresses, 4 for control and 5 for status, on both the write and read ports. Writes to codes 6 and 7 change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Instruction fetch presented this cycle |
| fetch_addr | input | 32 | Instruction address |
| dacc_valid | input | 1 | Data access presented this cycle |
| dacc_addr | input | 32 | Data access start address |
| dacc_size | input | 2 | Access size code, 2^code bytes |
| dacc_write | input | 1 | 1 for a write, 0 for a read |
| step_pulse | input | 1 | Single-step event |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Register write select |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_sel | input | 3 | Register read select |
| reg_rd_data | output | 32 | Selected register value |
| status_q | output | 32 | Status register |
| dbg_exc | output | 1 | Debug exception request pulse |

## Verification
Exact-equal and off-by-one fetch addresses separate the execute compare from any range logic. A disabled slot sharing an address with an enabled one shows that status reporting and exception gating are separate decisions. Reads and writes against each kind code separate the write-only, read-write and never-matching kinds. Accesses just inside and just outside the aligned region, for every length code, expose a wrong length decode or a missing alignment. Step pulses with and without a coincident fetch, and status writes colliding with checks, show which bits are sticky and which update wins.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

  typedef enum logic [1:0] {
    KIND_EXEC  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_PORT  = 2'd2,
    KIND_RDWR  = 2'd3
  } slot_kind_e;

  // Non-linear length code: 2 selects the widest region.
  function automatic logic [3:0] span_bytes(input logic [1:0] code);
    case (code)
      2'd0:    span_bytes = 4'd1;
      2'd1:    span_bytes = 4'd2;
      2'd2:    span_bytes = 4'd8;
      default: span_bytes = 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/dbg_rst_sync.sv
module dbg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/dbg_regs.sv
module dbg_regs #(
  parameter int          SLOTS      = 4,
  parameter int          AW         = 32,
  parameter int          DW         = 32,
  parameter logic [31:0] FIXED_ONES = 32'h0000_0400,
  localparam int         SEL_W      = $clog2(SLOTS + 2)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [SEL_W-1:0]         wr_sel,
  input  logic [DW-1:0]            wr_data,
  output logic [SLOTS-1:0][AW-1:0] addr_q,
  output logic [DW-1:0]            ctrl_q
);
  localparam logic [DW-1:0] FIX = DW'(FIXED_ONES);

  logic [SLOTS-1:0] addr_en;
  logic             ctrl_en;
  logic [DW-1:0]    ctrl_d;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      addr_en[i] = wr_en && (wr_sel == SEL_W'(i));
    end
    ctrl_en = wr_en && (wr_sel == SEL_W'(SLOTS));
    ctrl_d  = wr_data | FIX;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      ctrl_q <= FIX;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (addr_en[i]) addr_q[i] <= wr_data[AW-1:0];
      end
      if (ctrl_en) ctrl_q <= ctrl_d;
    end
  end
endmodule

// File: rtl/dbg_slot_cmp.sv
module dbg_slot_cmp
  import dbg_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          en_local,
  input  logic          en_global,
  input  logic [1:0]    kind,
  input  logic [1:0]    len_code,
  input  logic [AW-1:0] slot_addr,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic          dacc_valid,
  input  logic [AW-1:0] dacc_addr,
  input  logic [1:0]    dacc_size,
  input  logic          dacc_write,
  output logic          hit,
  output logic          enabled
);
  typedef logic [AW:0] ext_t;

  ext_t slot_lo, slot_hi, acc_lo, acc_hi, span, acc_len;
  logic overlap;

  always_comb begin
    span    = ext_t'(span_bytes(len_code));
    acc_len = ext_t'(4'd1 << dacc_size);
    slot_lo = {1'b0, slot_addr} & ~(span - ext_t'(1));
    slot_hi = slot_lo + span - ext_t'(1);
    acc_lo  = {1'b0, dacc_addr};
    acc_hi  = acc_lo + acc_len - ext_t'(1);
    overlap = (acc_lo <= slot_hi) && (slot_lo <= acc_hi);
    enabled = en_local | en_global;
    case (slot_kind_e'(kind))
      KIND_EXEC:  hit = fetch_valid && (fetch_addr == slot_addr);
      KIND_WRITE: hit = dacc_valid && dacc_write && overlap;
      KIND_RDWR:  hit = dacc_valid && overlap;
      default:    hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/dbg_status.sv
module dbg_status #(
  parameter int SLOTS    = 4,
  parameter int DW       = 32,
  parameter int STEP_BIT = 14,
  localparam int SEL_W   = $clog2(SLOTS + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] hit_vec,
  input  logic [SLOTS-1:0] en_vec,
  input  logic             step_pulse,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    status_q,
  output logic             exc_q
);
  logic          update;
  logic          wr_hit;
  logic [DW-1:0] status_d;

  always_comb begin
    update   = step_pulse || (|(hit_vec & en_vec));
    wr_hit   = wr_en && (wr_sel == SEL_W'(SLOTS + 1));
    status_d = status_q;
    if (update) begin
      status_d[SLOTS-1:0] = hit_vec;
      if (step_pulse) status_d[STEP_BIT] = 1'b1;
    end
    if (wr_hit) status_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      exc_q    <= 1'b0;
    end else begin
      exc_q <= update;
      if (update || wr_hit) status_q <= status_d;
    end
  end
endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit #(
  parameter int          SLOTS      = 4,
  parameter int          AW         = 32,
  parameter int          DW         = 32,
  parameter int          FIELD_BASE = 16,
  parameter int          STEP_BIT   = 14,
  parameter logic [31:0] FIXED_ONES = 32'h0000_0400,
  localparam int         SEL_W      = $clog2(SLOTS + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  input  logic [AW-1:0]    fetch_addr,
  input  logic             dacc_valid,
  input  logic [AW-1:0]    dacc_addr,
  input  logic [1:0]       dacc_size,
  input  logic             dacc_write,
  input  logic             step_pulse,
  input  logic             reg_wr_en,
  input  logic [SEL_W-1:0] reg_wr_sel,
  input  logic [DW-1:0]    reg_wr_data,
  input  logic [SEL_W-1:0] reg_rd_sel,
  output logic [DW-1:0]    reg_rd_data,
  output logic [DW-1:0]    status_q,
  output logic             dbg_exc
);
  logic                     rst_core_n;
  logic [SLOTS-1:0][AW-1:0] addr_q;
  logic [DW-1:0]            ctrl_q;
  logic [SLOTS-1:0]         hit_vec;
  logic [SLOTS-1:0]         en_vec;

  dbg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  dbg_regs #(
    .SLOTS(SLOTS), .AW(AW), .DW(DW), .FIXED_ONES(FIXED_ONES)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (reg_wr_en),
    .wr_sel  (reg_wr_sel),
    .wr_data (reg_wr_data),
    .addr_q  (addr_q),
    .ctrl_q  (ctrl_q)
  );

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    dbg_slot_cmp #(.AW(AW)) u_cmp (
      .en_local    (ctrl_q[2*g]),
      .en_global   (ctrl_q[2*g+1]),
      .kind        (ctrl_q[FIELD_BASE+4*g +: 2]),
      .len_code    (ctrl_q[FIELD_BASE+4*g+2 +: 2]),
      .slot_addr   (addr_q[g]),
      .fetch_valid (fetch_valid),
      .fetch_addr  (fetch_addr),
      .dacc_valid  (dacc_valid),
      .dacc_addr   (dacc_addr),
      .dacc_size   (dacc_size),
      .dacc_write  (dacc_write),
      .hit         (hit_vec[g]),
      .enabled     (en_vec[g])
    );
  end

  dbg_status #(
    .SLOTS(SLOTS), .DW(DW), .STEP_BIT(STEP_BIT)
  ) u_status (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .hit_vec    (hit_vec),
    .en_vec     (en_vec),
    .step_pulse (step_pulse),
    .wr_en      (reg_wr_en),
    .wr_sel     (reg_wr_sel),
    .wr_data    (reg_wr_data),
    .status_q   (status_q),
    .exc_q      (dbg_exc)
  );

  always_comb begin
    reg_rd_data = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (reg_rd_sel == SEL_W'(i)) reg_rd_data = DW'(addr_q[i]);
    end
    if (reg_rd_sel == SEL_W'(SLOTS))     reg_rd_data = ctrl_q;
    if (reg_rd_sel == SEL_W'(SLOTS + 1)) reg_rd_data = status_q;
  end
endmodule

// File: rtl/dbg_match_chk.sv
module dbg_match_chk #(
  parameter int          SLOTS      = 4,
  parameter int          DW         = 32,
  parameter int          FIELD_BASE = 16,
  parameter int          STEP_BIT   = 14,
  parameter logic [31:0] FIXED_ONES = 32'h0000_0400
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_valid,
  input logic             dacc_valid,
  input logic             step_pulse,
  input logic             reg_wr_en,
  input logic [DW-1:0]    ctrl_q,
  input logic [DW-1:0]    status_q,
  input logic [SLOTS-1:0] hit_vec,
  input logic             dbg_exc
);
  localparam logic [DW-1:0] FIX = DW'(FIXED_ONES);

  // R2
  fixed_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & FIX) == FIX);

  // R8
  step_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |=> dbg_exc);

  // R8
  step_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_pulse && !reg_wr_en) |=> status_q[STEP_BIT]);

  // R9
  exc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_exc |-> $past(step_pulse || fetch_valid || dacc_valid));

  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_pulse || fetch_valid || dacc_valid || reg_wr_en) |=> $stable(status_q));

  for (genvar g = 0; g < SLOTS; g++) begin : g_kind
    // R5
    port_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vec[g] |-> (ctrl_q[FIELD_BASE+4*g +: 2] != 2'd2));
  end
endmodule

bind dbg_match_unit dbg_match_chk #(
  .SLOTS(SLOTS), .DW(DW), .FIELD_BASE(FIELD_BASE),
  .STEP_BIT(STEP_BIT), .FIXED_ONES(FIXED_ONES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .fetch_valid (fetch_valid),
  .dacc_valid  (dacc_valid),
  .step_pulse  (step_pulse),
  .reg_wr_en   (reg_wr_en),
  .ctrl_q      (ctrl_q),
  .status_q    (status_q),
  .hit_vec     (hit_vec),
  .dbg_exc     (dbg_exc)
);

// File: tb/sim_dbg_match_unit.sv
module sim_dbg_match_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_valid, dacc_valid, dacc_write, step_pulse, reg_wr_en;
  logic [31:0] fetch_addr, dacc_addr, reg_wr_data, reg_rd_data, status_q;
  logic [1:0]  dacc_size;
  logic [2:0]  reg_wr_sel, reg_rd_sel;
  logic        dbg_exc;
  int          total = 0;
  int          bad = 0;
  bit          finished = 0;

  always #4 clk = ~clk;

  dbg_match_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .dacc_valid(dacc_valid), .dacc_addr(dacc_addr),
    .dacc_size(dacc_size), .dacc_write(dacc_write),
    .step_pulse(step_pulse),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
    .status_q(status_q), .dbg_exc(dbg_exc)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] d);
    reg_rd_sel = sel;
    #1;
    d = reg_rd_data;
  endtask

  task automatic do_fetch(input logic [31:0] a);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = a;
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  task automatic do_access(input logic [31:0] a, input logic [1:0] sz, input logic w);
    @(negedge clk);
    dacc_valid = 1'b1; dacc_addr = a; dacc_size = sz; dacc_write = w;
    @(negedge clk);
    dacc_valid = 1'b0;
  endtask

  task automatic do_step(input logic with_fetch, input logic [31:0] a);
    @(negedge clk);
    step_pulse = 1'b1; fetch_valid = with_fetch; fetch_addr = a;
    @(negedge clk);
    step_pulse = 1'b0; fetch_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 status after reset", status_q, 32'h0);
    check("R1 exception after reset", {31'b0, dbg_exc}, 32'h0);
    rd(3'd4, v); check("R1 control after reset", v, 32'h400);
    rd(3'd0, v); check("R1 slot0 address after reset", v, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(3'd4, 32'h0);
    rd(3'd4, v); check("R2 fixed-one bit kept", v, 32'h400);
    wr(3'd4, 32'h0000_0003);
    rd(3'd4, v); check("R2 control ORed", v, 32'h403);
    wr(3'd0, 32'h1000); wr(3'd1, 32'h1000);
    wr(3'd2, 32'h2000); wr(3'd3, 32'h3004);
    rd(3'd2, v); check("R11 slot2 address readback", v, 32'h2000);
    rd(3'd3, v); check("R11 slot3 address readback", v, 32'h3004);
    wr(3'd7, 32'hFFFF_FFFF); wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd0, v); check("R11 unmapped write leaves slot0", v, 32'h1000);
    rd(3'd4, v); check("R11 unmapped write leaves control", v, 32'h403);
    check("R11 unmapped write leaves status", status_q, 32'h0);
    rd(3'd6, v); check("R11 unmapped read is zero", v, 32'h0);
    rd(3'd7, v); check("R11 unmapped read 7 is zero", v, 32'h0);
  endtask

  task automatic t_exec();
    wr(3'd4, 32'h1);
    do_fetch(32'h1000);
    check("R4 exact fetch raises exception", {31'b0, dbg_exc}, 32'h1);
    check("R7 disabled slot1 reported too", status_q, 32'h3);
    @(negedge clk);
    check("R9 exception is one cycle", {31'b0, dbg_exc}, 32'h0);
    do_fetch(32'h1001);
    check("R4 off-by-one fetch no exception", {31'b0, dbg_exc}, 32'h0);
    check("R4 off-by-one fetch keeps status", status_q, 32'h3);
  endtask

  task automatic t_enable();
    wr(3'd5, 32'h0);
    wr(3'd4, 32'h0);
    do_fetch(32'h1000);
    check("R3 all disabled no exception", {31'b0, dbg_exc}, 32'h0);
    check("R3 all disabled no status update", status_q, 32'h0);
    wr(3'd4, 32'h8);
    do_fetch(32'h1000);
    check("R3 global enable slot1 exception", {31'b0, dbg_exc}, 32'h1);
    check("R3 global enable status", status_q, 32'h3);
  endtask

  task automatic t_kinds();
    wr(3'd4, 32'h0000_0010 | (32'd1 << 24));
    do_access(32'h2000, 2'd0, 1'b0);
    check("R5 write-only slot ignores read", {31'b0, dbg_exc}, 32'h0);
    check("R5 write-only read keeps status", status_q, 32'h3);
    do_access(32'h2000, 2'd0, 1'b1);
    check("R5 write-only slot on write", {31'b0, dbg_exc}, 32'h1);
    check("R7 status replaced by match vector", status_q, 32'h4);
    wr(3'd4, 32'h0000_0010 | (32'd3 << 24));
    wr(3'd5, 32'h0);
    do_access(32'h2000, 2'd0, 1'b0);
    check("R5 read-write slot on read", {31'b0, dbg_exc}, 32'h1);
    check("R5 read-write slot status", status_q, 32'h4);
    wr(3'd4, 32'h0000_0010 | (32'd2 << 24));
    wr(3'd5, 32'h0);
    do_access(32'h2000, 2'd0, 1'b1);
    check("R5 port kind never matches", {31'b0, dbg_exc}, 32'h0);
    check("R5 port kind status untouched", status_q, 32'h0);
  endtask

  task automatic probe(input string tag, input logic [31:0] a, input logic [1:0] sz, input logic exp);
    do_access(a, sz, 1'b0);
    check(tag, {31'b0, dbg_exc}, {31'b0, exp});
  endtask

  task automatic t_len();
    logic [31:0] base;
    base = 32'h0000_0040 | (32'd3 << 28);
    wr(3'd4, base | (32'd2 << 30));
    probe("R6 len8 aligned low edge", 32'h3000, 2'd0, 1'b1);
    check("R6 len8 status slot3", status_q, 32'h8);
    probe("R6 len8 past high edge", 32'h3008, 2'd0, 1'b0);
    probe("R6 len8 below region", 32'h2FFF, 2'd0, 1'b0);
    wr(3'd4, base | (32'd3 << 30));
    probe("R6 len4 lower word miss", 32'h3000, 2'd2, 1'b0);
    probe("R6 len4 eight-byte overlap", 32'h3000, 2'd3, 1'b1);
    probe("R6 len4 top byte", 32'h3007, 2'd0, 1'b1);
    wr(3'd4, base | (32'd1 << 30));
    probe("R6 len2 next byte miss", 32'h3006, 2'd0, 1'b0);
    probe("R6 len2 straddling halfword", 32'h3003, 2'd1, 1'b1);
    wr(3'd4, base);
    probe("R6 len1 neighbour miss", 32'h3005, 2'd0, 1'b0);
    probe("R6 len1 exact byte", 32'h3004, 2'd0, 1'b1);
  endtask

  task automatic t_step();
    wr(3'd4, 32'h0);
    wr(3'd5, 32'h0);
    do_step(1'b0, 32'h0);
    check("R8 step raises exception", {31'b0, dbg_exc}, 32'h1);
    check("R8 step sets step bit", status_q, 32'h4000);
    wr(3'd4, 32'h1);
    do_fetch(32'h1000);
    check("R8 step bit kept across check", status_q, 32'h4003);
    wr(3'd4, 32'h0);
    wr(3'd5, 32'h0);
    do_step(1'b1, 32'h1000);
    check("R8 step with disabled matches", status_q, 32'h4003);
    check("R8 step exception with disabled slots", {31'b0, dbg_exc}, 32'h1);
  endtask

  task automatic t_keep();
    wr(3'd4, 32'h1);
    wr(3'd5, 32'hA000_0000);
    do_fetch(32'h1000);
    check("R10 upper status bits kept", status_q, 32'hA000_0003);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = 3'd5; reg_wr_data = 32'h5;
    fetch_valid = 1'b1; fetch_addr = 32'h1000;
    @(negedge clk);
    reg_wr_en = 1'b0; fetch_valid = 1'b0;
    check("R10 status write wins over check", status_q, 32'h5);
    check("R10 exception still raised", {31'b0, dbg_exc}, 32'h1);
  endtask

  initial begin
    rst_n = 1'b0;
    fetch_valid = 1'b0; fetch_addr = '0;
    dacc_valid = 1'b0; dacc_addr = '0; dacc_size = '0; dacc_write = 1'b0;
    step_pulse = 1'b0; reg_wr_en = 1'b0; reg_wr_sel = '0; reg_wr_data = '0;
    reg_rd_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_exec();
    t_enable();
    t_kinds();
    t_len();
    t_step();
    t_keep();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R9 watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule